// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Address Strobes

This block produces the per-cycle word address for a synchronous burst SRAM core. Two active-low address strobes can start an access: a processor-side strobe and a controller-side strobe. A processor-side start is qualified by the main chip enable and is always a read. A controller-side start is never blocked by that enable, and it takes its read or write kind from the write enables sampled on the same edge. After a start, an active-low advance input steps the two low address bits through a four-beat burst. Leaving advance inactive holds the current beat, which inserts a wait state.

The burst order is chosen by a select input. When the select is high, the beat number is XORed into the two low start bits (interleaved order). When it is low, the beat number is added modulo 4 (linear order). The count wraps within the four-word block and never carries into the upper address bits. The outputs are a registered cycle-valid flag, a read/write indication for the core, and the address. The storage array and the data path belong to other blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and on the first cycle after it, `cyc_valid` is 0, `cyc_write` is 0 and `mem_addr` is 0.
- R2: On an edge where `ctl_strobe_n` is 0 and the processor-side start is not taken, `mem_addr` becomes `ext_addr` on the next cycle. `cyc_valid` becomes 1 only if both `cs_main_n` and `cs_aux_n` are 0. `cyc_write` becomes 1 if `wr_all_n` is 0 or any bit of `wr_lane_n` is 0.
- R3: On an edge where `proc_strobe_n` and `cs_main_n` are both 0, the external address is loaded and `cyc_write` becomes 0, whatever the write enables and `ctl_strobe_n` are. `cyc_valid` becomes the inverse of `cs_aux_n`.
- R4: A `proc_strobe_n` pulse while `cs_main_n` is 1 starts nothing. If `ctl_strobe_n` is 0 on the same edge, the controller-side start of R2 takes place. If it is 1, the state moves exactly as with no strobe.
- R5: With `order_sel` = 0, beat k of a burst that starts at low bits s drives `mem_addr[1:0]` = (s + k) mod 4.
- R6: With `order_sel` = 1, beat k drives `mem_addr[1:0]` = s XOR k.
- R7: On an edge without a load where `adv_n` is 1, `mem_addr`, `cyc_valid` and `cyc_write` keep their values.
- R8: Every non-load edge with `adv_n` = 0 and `cyc_valid` = 1 moves to the next beat. After the fourth beat the count wraps back to beat 0. `mem_addr[16:2]` changes only on a load.
- R9: On an edge that loads an address, `adv_n` has no effect: the next cycle is always beat 0.
- R10: A controller-side strobe in the middle of a burst replaces the burst with the new address at beat 0.
- R11: After a start with `cyc_valid` = 0, `adv_n` = 0 does not change `mem_addr`.
- R12: The write enables act only on a controller-side load edge. On other edges, changing them leaves `cyc_write` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 1 selects interleaved order, 0 selects linear order |
| cs_main_n | input | 1 | Main chip enable, active low; gates the processor-side strobe |
| cs_aux_n | input | 1 | Second chip enable, active low |
| wr_all_n | input | 1 | Write of all byte lanes, active low |
| wr_lane_n | input | 2 | Per-lane write enables, active low |
| ext_addr | input | 17 | External start address |
| mem_addr | output | 17 | Address for the current cycle |
| cyc_write | output | 1 | 1 for a write cycle, 0 for a read cycle |
| cyc_valid | output | 1 | 1 while the current cycle selects the core |

## Verification
The hardest case to reach is an edge where several controls compete. Examples are both strobes low while the main enable is blocking, an advance pulse on the same edge as a load, and a reload partway through a burst that has already wrapped. The bench sweeps both orders, all four low start values and several wait-state positions in nested loops. It then drives each of these conflict edges on purpose at known beats. It compares the address against the modulo sum or XOR, computed in the bench.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits for a given beat of the burst.
  function automatic beat_t beat_low(beat_t start, beat_t beat, logic inter);
    beat_t r;
    if (inter) r = start ^ beat;
    else       r = start + beat;
    return r;
  endfunction
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode #(
  parameter int LANES = 2
) (
  input  logic             proc_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             cs_main_n,
  input  logic             cs_aux_n,
  input  logic             wr_all_n,
  input  logic [LANES-1:0] wr_lane_n,
  output logic             load,
  output logic             load_valid,
  output logic             load_write
);
  logic proc_go;
  logic ctl_go;
  logic any_wr;

  always_comb begin
    proc_go    = ~proc_strobe_n & ~cs_main_n;
    ctl_go     = ~ctl_strobe_n & ~proc_go;
    any_wr     = ~wr_all_n | ~(&wr_lane_n);
    load       = proc_go | ctl_go;
    load_valid = ~cs_main_n & ~cs_aux_n;
    load_write = ctl_go & any_wr;
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output beat_t beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat + beat_t'(1);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic              cs_main_n,
  input  logic              cs_aux_n,
  input  logic              wr_all_n,
  input  logic [LANES-1:0]  wr_lane_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cyc_write,
  output logic              cyc_valid
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic            load_ev;
  logic            load_valid;
  logic            load_write;
  logic            step_ev;
  beat_t           beat;
  logic [HI_W-1:0] base_hi;
  beat_t           base_lo;

  strobe_decode #(.LANES(LANES)) u_dec (
    .proc_strobe_n(proc_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .cs_main_n    (cs_main_n),
    .cs_aux_n     (cs_aux_n),
    .wr_all_n     (wr_all_n),
    .wr_lane_n    (wr_lane_n),
    .load         (load_ev),
    .load_valid   (load_valid),
    .load_write   (load_write)
  );

  assign step_ev = ~load_ev & ~adv_n & cyc_valid;

  burst_counter u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_ev),
    .step (step_ev),
    .beat (beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi   <= '0;
      base_lo   <= '0;
      cyc_valid <= 1'b0;
      cyc_write <= 1'b0;
    end else if (load_ev) begin
      base_hi   <= ext_addr[ADDR_W-1:BEAT_W];
      base_lo   <= ext_addr[BEAT_W-1:0];
      cyc_valid <= load_valid;
      cyc_write <= load_write;
    end
  end

  assign mem_addr = {base_hi, beat_low(base_lo, beat, order_sel)};
endmodule

// File: rtl/burst_addr_seq_check.sv
module burst_addr_seq_check #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strobe_n,
  input logic              cs_main_n,
  input logic              cs_aux_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cyc_write,
  input logic              cyc_valid,
  input logic              load_ev
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_proc_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!proc_strobe_n && !cs_main_n)) |->
      (!cyc_write && mem_addr == $past(ext_addr) && cyc_valid == !$past(cs_aux_n)));

  assert_load_beat0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(load_ev)) |-> (mem_addr == $past(ext_addr)));

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!load_ev && adv_n) && $stable(order_sel)) |->
      ($stable(mem_addr) && $stable(cyc_write) && $stable(cyc_valid)));

  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!load_ev)) |->
      (mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!load_ev && !cyc_valid) && $stable(order_sel)) |->
      $stable(mem_addr));
endmodule

bind burst_addr_seq burst_addr_seq_check #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .proc_strobe_n(proc_strobe_n),
  .cs_main_n    (cs_main_n),
  .cs_aux_n     (cs_aux_n),
  .adv_n        (adv_n),
  .order_sel    (order_sel),
  .ext_addr     (ext_addr),
  .mem_addr     (mem_addr),
  .cyc_write    (cyc_write),
  .cyc_valid    (cyc_valid),
  .load_ev      (load_ev)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        proc_strobe_n = 1'b1;
  logic        ctl_strobe_n = 1'b1;
  logic        adv_n = 1'b1;
  logic        order_sel = 1'b0;
  logic        cs_main_n = 1'b0;
  logic        cs_aux_n = 1'b0;
  logic        wr_all_n = 1'b1;
  logic [1:0]  wr_lane_n = 2'b11;
  logic [16:0] ext_addr = '0;
  logic [16:0] mem_addr;
  logic        cyc_write;
  logic        cyc_valid;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n), .order_sel(order_sel),
    .cs_main_n(cs_main_n), .cs_aux_n(cs_aux_n), .wr_all_n(wr_all_n),
    .wr_lane_n(wr_lane_n), .ext_addr(ext_addr), .mem_addr(mem_addr),
    .cyc_write(cyc_write), .cyc_valid(cyc_valid)
  );

  task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock edge, inputs settle at posedge+5
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    proc_strobe_n = 1'b1; ctl_strobe_n = 1'b1; adv_n = 1'b1;
    wr_all_n = 1'b1; wr_lane_n = 2'b11;
  endtask

  function automatic logic [1:0] exp_low(logic [1:0] s, int k, logic inter);
    logic [1:0] kk;
    kk = 2'(k % 4);
    return inter ? (s ^ kk) : 2'((int'(s) + int'(kk)) % 4);
  endfunction

  task automatic ctl_load(logic [16:0] a, logic wr);
    idle();
    ctl_strobe_n = 1'b0; ext_addr = a; wr_all_n = ~wr;
    tick();
    idle();
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [16:0] a;
    int beat;
    // R1 reset state
    #15;
    chk("R1 addr", mem_addr, 17'h0);
    chk("R1 valid", 17'(cyc_valid), 17'h0);
    chk("R1 write", 17'(cyc_write), 17'h0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk("R1 first cycle valid", 17'(cyc_valid), 17'h0);
    chk("R1 first cycle addr", mem_addr, 17'h0);

    // R5/R6/R7/R8 sweep: orders, start lows, wait-state positions
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int w = 0; w < 3; w++) begin
          order_sel = m[0];
          a = {15'(17'h5A5 + 33 * s + 7 * w), 2'(s)};
          ctl_load(a, 1'b0);
          chk("R2 load addr", mem_addr, a);
          chk("R2 load valid", 17'(cyc_valid), 17'h1);
          beat = 0;
          for (int k = 0; k < 7; k++) begin
            adv_n = (k == w + 1) ? 1'b1 : 1'b0;
            tick();
            if (!adv_n) beat++;
            chk(m ? "R6 interleaved beat" : "R5 linear beat", 17'(mem_addr[1:0]),
                17'(exp_low(2'(s), beat, m[0])));
            chk("R8 upper fixed", 17'(mem_addr[16:2]), 17'(a[16:2]));
            if (adv_n) chk("R7 wait holds", 17'(mem_addr[1:0]),
                           17'(exp_low(2'(s), beat, m[0])));
          end
          idle();
        end
      end
    end

    // R2 controller write with lane enable
    order_sel = 1'b0;
    idle(); ctl_strobe_n = 1'b0; ext_addr = 17'h1ABCD; wr_lane_n = 2'b10;
    tick(); idle();
    chk("R2 lane write", 17'(cyc_write), 17'h1);
    // R12 write enables ignored off the load edge
    wr_lane_n = 2'b11; wr_all_n = 1'b1; adv_n = 1'b0;
    tick();
    chk("R12 write held", 17'(cyc_write), 17'h1);
    chk("R8 step", 17'(mem_addr[1:0]), 17'h2);
    idle();

    // R3 processor strobe priority, read even with writes low
    proc_strobe_n = 1'b0; ctl_strobe_n = 1'b0; ext_addr = 17'h03332;
    wr_all_n = 1'b0; cs_main_n = 1'b0;
    tick(); idle();
    chk("R3 addr", mem_addr, 17'h03332);
    chk("R3 read", 17'(cyc_write), 17'h0);
    chk("R3 valid", 17'(cyc_valid), 17'h1);

    // R4 blocked processor strobe, controller acts (write, deselected)
    proc_strobe_n = 1'b0; ctl_strobe_n = 1'b0; cs_main_n = 1'b1;
    ext_addr = 17'h0F0F1; wr_all_n = 1'b0;
    tick(); idle();
    chk("R4 ctl takes over addr", mem_addr, 17'h0F0F1);
    chk("R4 ctl write", 17'(cyc_write), 17'h1);
    chk("R4 valid off main", 17'(cyc_valid), 17'h0);
    // R11 deselected: advance does nothing
    adv_n = 1'b0;
    tick(); tick();
    chk("R11 no step", mem_addr, 17'h0F0F1);
    idle(); cs_main_n = 1'b0;

    // R4 blocked processor strobe alone: state unchanged
    ctl_load(17'h12340, 1'b0);
    cs_main_n = 1'b1; proc_strobe_n = 1'b0; ext_addr = 17'h00003;
    tick(); idle(); cs_main_n = 1'b0;
    chk("R4 ignored", mem_addr, 17'h12340);

    // R9 advance on load edge ignored
    ctl_strobe_n = 1'b0; adv_n = 1'b0; ext_addr = 17'h00501;
    tick(); idle();
    chk("R9 beat0", mem_addr, 17'h00501);

    // R10 reload mid-burst after wrap
    order_sel = 1'b1;
    adv_n = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    chk("R8 wrap interleaved", 17'(mem_addr[1:0]), 17'(exp_low(2'd1, 5, 1'b1)));
    ctl_strobe_n = 1'b0; ext_addr = 17'h1FFFE;
    tick(); ctl_strobe_n = 1'b1;
    chk("R10 reload", mem_addr, 17'h1FFFE);
    tick(); idle();
    chk("R10 next beat", mem_addr, 17'h1FFFF);

    // R3 aux enable deselects processor cycle
    cs_aux_n = 1'b1; proc_strobe_n = 1'b0; ext_addr = 17'h00044;
    tick(); idle(); cs_aux_n = 1'b0;
    chk("R3 aux deselect", 17'(cyc_valid), 17'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule